// File: doc/BRIEF.md
# Pointer-Anchored Wrapping Immediate Loader

This block writes an immediate constant of 1 to 16 nibbles into a 64-bit working register. The register's previous contents are captured when a load starts. The first constant nibble lands at the nibble named by a run-time pointer. Later nibbles go to ascending positions and wrap from the top nibble back to nibble 0. Nibbles outside this circular window keep their captured value.

The constant arrives one nibble per request. The block raises a request strobe, together with the index of the constant nibble it wants, and samples the nibble input on the same clock edge. Requests are spaced so that a load of n nibbles keeps the block busy for ceil((5 + 3n)/2) cycles, which is one and a half cycles per nibble plus a fixed two and a half cycles. A one-cycle completion strobe marks the final busy cycle, when the register already holds its final value. A start request made while a load is running is refused.

Top module: `imm_wrap_loader`

## Requirements
- R1: After reset, `busy`, `done` and `nib_req` are low and `reg_out` is all zeros.
- R2: `start` sampled high while `busy` is low accepts a load. It captures `reg_in`, `ptr` and `cnt_m1`, where `cnt_m1` holds the nibble count minus one, so 0..15 means 1..16. From the next cycle `busy` is high and `reg_out` equals the captured `reg_in` until the first nibble is written.
- R3: Constant nibble k (k = 0 is the least significant) is written to register nibble (`ptr` + k) mod 16. Register nibble i occupies bits 4i+3..4i.
- R4: A window that passes nibble 15 continues at nibble 0. For example, a pointer of 9 with a count of 8 writes nibbles 9 through 15 and then nibble 0.
- R5: A count of 16 replaces every nibble of the register, whatever the pointer value.
- R6: Register nibbles outside the written window keep the value captured at the start.
- R7: A load of n nibbles keeps `busy` high for exactly floor((6 + 3n)/2) cycles, which equals ceil(2.5 + 1.5n).
- R8: `done` is high for exactly one cycle, the last busy cycle. All n nibbles have been written by then. `reg_out` holds its final value in that cycle and afterwards while idle.
- R9: `start` is ignored while `busy` is high, including the cycle in which `done` is high. The running load's parameters and result are unaffected.
- R10: `nib_req` is high only while busy. It rises exactly n times per load. Request k carries `nib_idx` = k and falls in busy cycle 2 + floor(3k/2), counting the first busy cycle as 0. `imm_nib` is sampled at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request, accepted only when idle |
| ptr | input | 4 | Nibble position of the first write |
| cnt_m1 | input | 4 | Nibble count minus one |
| reg_in | input | 64 | Register value before the load |
| imm_nib | input | 4 | Requested constant nibble |
| nib_req | output | 1 | Constant nibble is sampled at this cycle's end |
| nib_idx | output | 4 | Index of the requested constant nibble |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion strobe |
| reg_out | output | 64 | Working register value |

## Verification
Two events can coincide: a new `start` can arrive in the same cycle that `done` closes a running load. A second `start` can also arrive in the middle of a load. On every load, the bench raises `start` again in busy cycle 1, with a different pointer, count and register value. It raises `start` once more in the `done` cycle. It judges refusal by three things: the busy length still matches the first load's count, the final register matches only the first load's parameters, and `busy` is low in the cycle after `done`. The sweep covers every pointer with every count, so every wrap point and the full-width case meet both collisions.

// File: rtl/imm_wrap_loader_pkg.sv
package imm_wrap_loader_pkg;

  // Busy length of a load of n nibbles: ceil((5 + 3n) / 2).
  function automatic int load_cycles(int n);
    return (6 + 3 * n) / 2;
  endfunction

  // Busy cycle in which constant nibble k is taken.
  function automatic int nib_slot(int k);
    return 2 + (3 * k) / 2;
  endfunction

  // Next nibble position, circular over nibs positions.
  function automatic int nib_wrap(int pos, int nibs);
    return (pos + 1 >= nibs) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/iwl_pacer.sv
module iwl_pacer
  import imm_wrap_loader_pkg::*;
#(
  parameter int NIBS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [$clog2(NIBS)-1:0] cnt_m1,
  output logic                    busy_o,
  output logic                    step_o,
  output logic [$clog2(NIBS)-1:0] idx_o,
  output logic                    last_o
);
  localparam int IW = $clog2(NIBS);
  localparam int CW = $clog2(NIBS + 1);
  localparam int TW = $clog2(load_cycles(NIBS) + 1);

  logic          busy_q;
  logic [TW-1:0] t_q;
  logic [CW-1:0] k_q;
  logic [CW-1:0] n_q;
  logic [TW-1:0] slot_now;
  logic [TW-1:0] t_last;

  always_comb begin
    slot_now = TW'(nib_slot(int'(k_q)));
    t_last   = TW'(load_cycles(int'(n_q)) - 1);
    step_o   = busy_q && (k_q < n_q) && (t_q == slot_now);
    last_o   = busy_q && (t_q == t_last);
    busy_o   = busy_q;
    idx_o    = k_q[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      t_q    <= '0;
      k_q    <= '0;
      n_q    <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      t_q    <= '0;
      k_q    <= '0;
      n_q    <= CW'(cnt_m1) + CW'(1);
    end else if (busy_q) begin
      t_q <= t_q + TW'(1);
      if (step_o) k_q <= k_q + CW'(1);
      if (last_o) busy_q <= 1'b0;
    end
  end

  AST_ALL_WRITTEN_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (k_q == n_q)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (!last_o && !busy_q)); // R8
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (busy_q && $stable(n_q))); // R9
endmodule

// File: rtl/iwl_nibwr.sv
module iwl_nibwr
  import imm_wrap_loader_pkg::*;
#(
  parameter int NIBS = 16,
  parameter int NW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [$clog2(NIBS)-1:0] ptr,
  input  logic [NIBS*NW-1:0]      reg_in,
  input  logic                    step,
  input  logic [NW-1:0]           imm_nib,
  output logic [NIBS*NW-1:0]      reg_out
);
  localparam int IW = $clog2(NIBS);

  logic [IW-1:0] pos_q;
  logic [NW-1:0] nib_q [NIBS];

  always_ff @(posedge clk) begin
    if (!rst_n)       pos_q <= '0;
    else if (accept)  pos_q <= ptr;
    else if (step)    pos_q <= IW'(nib_wrap(int'(pos_q), NIBS));
  end

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    always_ff @(posedge clk) begin
      if (!rst_n)                           nib_q[g] <= '0;
      else if (accept)                      nib_q[g] <= reg_in[g*NW +: NW];
      else if (step && (pos_q == IW'(g)))   nib_q[g] <= imm_nib;
    end
    assign reg_out[g*NW +: NW] = nib_q[g];
  end

  AST_NIBBLE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (nib_q[$past(pos_q)] == $past(imm_nib))); // R3
endmodule

// File: rtl/imm_wrap_loader.sv
module imm_wrap_loader
  import imm_wrap_loader_pkg::*;
#(
  parameter int NIBS = 16,
  parameter int NW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [$clog2(NIBS)-1:0] ptr,
  input  logic [$clog2(NIBS)-1:0] cnt_m1,
  input  logic [NIBS*NW-1:0]      reg_in,
  input  logic [NW-1:0]           imm_nib,
  output logic                    nib_req,
  output logic [$clog2(NIBS)-1:0] nib_idx,
  output logic                    busy,
  output logic                    done,
  output logic [NIBS*NW-1:0]      reg_out
);
  logic accept;
  logic step;

  assign accept  = start && !busy;
  assign nib_req = step;

  iwl_pacer #(.NIBS(NIBS)) i_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .cnt_m1 (cnt_m1),
    .busy_o (busy),
    .step_o (step),
    .idx_o  (nib_idx),
    .last_o (done)
  );

  iwl_nibwr #(.NIBS(NIBS), .NW(NW)) i_nibwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .ptr     (ptr),
    .reg_in  (reg_in),
    .step    (step),
    .imm_nib (imm_nib),
    .reg_out (reg_out)
  );

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nib_req |-> busy); // R10
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && (reg_out == $past(reg_in)))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(reg_out)); // R8
endmodule

// File: tb/test_imm_wrap_loader.sv
module test_imm_wrap_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  ptr = '0;
  logic [3:0]  cnt_m1 = '0;
  logic [63:0] reg_in = '0;
  logic [3:0]  imm_nib = '0;
  logic        nib_req;
  logic [3:0]  nib_idx;
  logic        busy;
  logic        done;
  logic [63:0] reg_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_wrap_loader i_imm_wrap_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr(ptr), .cnt_m1(cnt_m1),
    .reg_in(reg_in), .imm_nib(imm_nib), .nib_req(nib_req), .nib_idx(nib_idx),
    .busy(busy), .done(done), .reg_out(reg_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic do_load(input int p, input int n);
    logic [63:0] rv, cv, expv, mask;
    int c, k, t_exp, bad_req;
    bit saw_done;
    string wreq;
    seed = next_rand(seed); rv = seed;
    seed = next_rand(seed); cv = seed;
    expv = rv; mask = '0;
    for (int j = 0; j < n; j++) begin
      expv[((p + j) % 16) * 4 +: 4] = cv[j*4 +: 4];
      mask[((p + j) % 16) * 4 +: 4] = 4'hF;
    end
    t_exp = (6 + 3 * n) / 2;
    wreq = (n == 16) ? "R5" : ((p + n > 16) ? "R4" : "R3");
    @(negedge clk);
    start = 1'b1; ptr = 4'(p); cnt_m1 = 4'(n - 1); reg_in = rv;
    @(negedge clk);
    start = 1'b0;
    c = 0; k = 0; bad_req = 0; saw_done = 1'b0;
    while (busy && c < 40) begin
      if (c == 0) chk(reg_out == rv, "R2 captured register", reg_out, rv);
      if (c == 1) begin  // R9: intruding start mid-load
        start = 1'b1; ptr = ~ptr; cnt_m1 = ~cnt_m1; reg_in = ~rv;
      end
      if (c == 2) start = 1'b0;
      if (nib_req) begin
        if (int'(nib_idx) != k || c != 2 + (3 * k) / 2) bad_req++;
        imm_nib = cv[(k % 16) * 4 +: 4];
        k++;
      end
      if (done) begin
        saw_done = 1'b1;
        chk(c == t_exp - 1, "R8 done in last busy cycle", 64'(c), 64'(t_exp - 1));
        chk(reg_out == expv, wreq, reg_out, expv);
        if (n < 16)
          chk((reg_out & ~mask) == (rv & ~mask), "R6 outside window", reg_out & ~mask, rv & ~mask);
        start = 1'b1;  // R9: start in the done cycle
      end
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    chk(saw_done, "R8 done seen", 64'(saw_done), 64'd1);
    chk(c == t_exp, "R7 busy length", 64'(c), 64'(t_exp));
    chk(k == n && bad_req == 0, "R10 request schedule", 64'(k), 64'(n));
    @(negedge clk);
    chk(!busy && reg_out == expv, "R9 refused start and R8 hold", reg_out, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !nib_req && reg_out == '0, "R1 reset state",
        {reg_out[60:0], busy, done, nib_req}, 64'd0);
    rst_n = 1'b1;
    // The wrap example from R4: pointer 9, count 8
    do_load(9, 8);
    for (int p = 0; p < 16; p++)
      for (int n = 1; n <= 16; n++)
        do_load(p, n);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule